// File: doc/BRIEF.md
# Address-Tagged Register Window Cache

This block stores scalar integer operands in a small pool of physical register windows. Each window holds eight 32-bit words and carries the memory base address it stands for. At any moment two of these windows are visible through two logical slots, 0 and 1. Operands name a slot and a word index. Two read ports and one write port work on the visible windows. The pool holds more windows than the two slots, and nothing outside the block can see how many.

A command binds a slot to a memory address. The load kind fetches eight consecutive words starting at that address. The allocate kind claims a window for the address without reading memory. If the address already belongs to a resident window, that window is reused and memory is not touched. Any write marks its window dirty. Dirty windows are copied back one word per cycle through the shared data-cache port. This copy-back only runs in cycles where no other unit is using that port.

When the block needs a window and none is free, it picks a clean window that is not bound to a slot. Windows bound to a slot are never taken. If every unbound window is dirty, the command waits until a copy-back has cleaned one.

Top module: `regwin_cache`

## Requirements
- R1: After reset the block has no windows resident and no slots bound. `mem_req`, `cmd_ready` and `rd_stall` are low, and both read ports return zero.
- R2: A load command (`cmd_alloc`=0) that misses issues eight read beats (`mem_we`=0) at base+4·k for k=0..7. `mem_rdata` is captured in the cycle a beat is accepted. `cmd_ready` rises in the cycle the eighth beat is accepted, so a miss completes on its ninth cycle. After that, slot word k returns the k-th fetched word.
- R3: A read port returns word `rdN_idx` of the window bound to slot `rdN_sel`. A write (`wr_en`, `wr_sel`, `wr_idx`, `wr_data`) is visible on both read ports from the next cycle.
- R4: Any enabled read or write that names the slot currently being filled raises `rd_stall`. A write made while `rd_stall` is high is dropped.
- R5: An allocate command (`cmd_alloc`=1) that misses completes in the cycle it is presented and issues no read beat. Every word of the claimed window then reads zero.
- R6: A load or allocate whose address equals the base address of a resident window binds that window to the slot. It completes in the cycle it is presented, issues no read beat, and keeps the window's contents.
- R7: A write marks its window dirty. A dirty window is copied back with eight write beats (`mem_we`=1) at base+4·k, one word per accepted beat. Its dirty mark is cleared after the eighth beat.
- R8: While `ext_busy` is high, `mem_req` is low. This covers both fill and copy-back traffic.
- R9: A window is claimed in this order: an unused window first, then a clean window not bound to a slot. A window bound to a slot is never claimed. If neither kind exists, `cmd_ready` stays low until a copy-back cleans a window, and the command completes in the cycle after that copy-back's last beat.
- R10: A write to the window being copied back restarts the copy-back from word 0, and the window stays dirty. Memory ends up holding the newest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; held until `cmd_ready` |
| cmd_alloc | input | 1 | 0 = load from memory, 1 = allocate without reading |
| cmd_slot | input | 1 | Logical slot to bind |
| cmd_addr | input | 32 | Window base byte address |
| cmd_ready | output | 1 | Command completes this cycle |
| rd0_en | input | 1 | Read port 0 in use (for stall) |
| rd0_sel | input | 1 | Read port 0 slot |
| rd0_idx | input | 3 | Read port 0 word index |
| rd0_data | output | 32 | Read port 0 data |
| rd1_en | input | 1 | Read port 1 in use (for stall) |
| rd1_sel | input | 1 | Read port 1 slot |
| rd1_idx | input | 3 | Read port 1 word index |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 1 | Write slot |
| wr_idx | input | 3 | Write word index |
| wr_data | input | 32 | Write data |
| rd_stall | output | 1 | An operand access names a slot still being filled |
| ext_busy | input | 1 | Another unit owns the data-cache port this cycle |
| mem_req | output | 1 | Data-cache request |
| mem_we | output | 1 | 1 = write beat (copy-back), 0 = read beat (fill) |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Copy-back data |
| mem_rdata | input | 32 | Fill data, valid when a read beat is accepted |
| mem_ready | input | 1 | Data cache accepts the beat this cycle |

## Verification
The hardest state to reach from the ports is the victim stall. Every unbound window must be dirty, and the copy-back that would free one must be held off. The stimulus raises `ext_busy`, dirties the two windows bound by the first loads, and then allocates two new addresses so that those dirty windows become unbound. A fifth address then has to wait. Once `ext_busy` is released, the wait must last exactly one full copy-back plus one cycle. The copy-back restart is reached by writing the same word twice, a few beats apart. Both the beat count and the final memory word are checked.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int ADDR_W = 32;
  localparam int BYTES_PER_WORD = 4;

  typedef enum logic {
    K_LOAD  = 1'b0,
    K_ALLOC = 1'b1
  } cmd_kind_e;

  // Byte address of word k of a window based at base.
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input int unsigned k);
    return base + ADDR_W'(k * BYTES_PER_WORD);
  endfunction

endpackage

// File: rtl/regwin_select.sv
// Tag lookup and victim choice over the whole pool; lowest index wins.
module regwin_select #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic [NWIN-1:0] valid,
  input  logic [NWIN-1:0] dirty,
  input  logic [NWIN-1:0] bound,
  input  logic [AW-1:0]   tags [NWIN],
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IW-1:0]   hit_idx,
  output logic            vic_ok,
  output logic [IW-1:0]   vic_idx
);
  logic          free_ok, clean_ok;
  logic [IW-1:0] free_idx, clean_idx;

  always_comb begin
    hit = 1'b0;      hit_idx = '0;
    free_ok = 1'b0;  free_idx = '0;
    clean_ok = 1'b0; clean_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (valid[i] && tags[i] == addr) begin
        hit = 1'b1; hit_idx = IW'(i);
      end
      if (!valid[i]) begin
        free_ok = 1'b1; free_idx = IW'(i);
      end
      if (valid[i] && !dirty[i] && !bound[i]) begin
        clean_ok = 1'b1; clean_idx = IW'(i);
      end
    end
    vic_ok  = free_ok | clean_ok;
    vic_idx = free_ok ? free_idx : clean_idx;
  end
endmodule

// File: rtl/regwin_spiller.sv
// Copy-back engine: one dirty window at a time, one word per accepted beat.
module regwin_spiller #(
  parameter int NWIN  = 4,
  parameter int WORDS = 8,
  localparam int IW   = $clog2(NWIN),
  localparam int XW   = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NWIN-1:0] cand,
  input  logic            go,
  input  logic            accept,
  input  logic            restart,
  output logic            busy,
  output logic [IW-1:0]   win,
  output logic [XW-1:0]   idx,
  output logic            req,
  output logic            done
);
  logic          pick_ok;
  logic [IW-1:0] pick;
  logic          beat, last;

  always_comb begin
    pick_ok = 1'b0; pick = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_ok = 1'b1; pick = IW'(i);
      end
    end
  end

  assign req  = busy & go;
  assign beat = req & accept;
  assign last = (idx == XW'(WORDS - 1));
  assign done = beat & last & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      win  <= '0;
      idx  <= '0;
    end else if (!busy) begin
      if (pick_ok) begin
        busy <= 1'b1;
        win  <= pick;
        idx  <= '0;
      end
    end else if (restart) begin
      idx <= '0;
    end else if (beat) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + XW'(1);
    end
  end
endmodule

// File: rtl/regwin_cache.sv
module regwin_cache
  import regwin_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NWIN),
  localparam int XW   = $clog2(WORDS),
  localparam int AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_alloc,
  input  logic          cmd_slot,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  input  logic          rd0_en,
  input  logic          rd0_sel,
  input  logic [XW-1:0] rd0_idx,
  output logic [DW-1:0] rd0_data,
  input  logic          rd1_en,
  input  logic          rd1_sel,
  input  logic [XW-1:0] rd1_idx,
  output logic [DW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [XW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          rd_stall,
  input  logic          ext_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  // Pool state
  logic [NWIN-1:0] valid_q, dirty_q, bound;
  logic [AW-1:0]   tag_q  [NWIN];
  logic [DW-1:0]   data_q [NWIN][WORDS];
  logic [IW-1:0]   act_q  [2];
  logic [1:0]      act_ok_q;

  // Fill sequencer state
  logic            fill_busy;
  logic [IW-1:0]   fill_win;
  logic [XW-1:0]   fill_cnt;

  // Named internal events
  logic            hit, vic_ok, vic_take, cmd_go;
  logic [IW-1:0]   hit_idx, vic_idx;
  logic [1:0]      slot_filling;
  logic            wr_fire, fill_beat, fill_last;
  logic [IW-1:0]   wr_win;
  logic            spill_busy, spill_req, spill_done, spill_restart;
  logic [IW-1:0]   spill_win;
  logic [XW-1:0]   spill_idx;

  always_comb begin
    for (int i = 0; i < NWIN; i++)
      bound[i] = (act_ok_q[0] && act_q[0] == IW'(i)) ||
                 (act_ok_q[1] && act_q[1] == IW'(i));
  end

  regwin_select #(.NWIN(NWIN), .AW(AW)) u_select (
    .valid(valid_q), .dirty(dirty_q), .bound(bound), .tags(tag_q),
    .addr(cmd_addr), .hit(hit), .hit_idx(hit_idx),
    .vic_ok(vic_ok), .vic_idx(vic_idx)
  );

  regwin_spiller #(.NWIN(NWIN), .WORDS(WORDS)) u_spiller (
    .clk(clk), .rst_n(rst_n), .cand(dirty_q & valid_q),
    .go(~ext_busy & ~fill_busy), .accept(mem_ready), .restart(spill_restart),
    .busy(spill_busy), .win(spill_win), .idx(spill_idx),
    .req(spill_req), .done(spill_done)
  );

  generate
    for (genvar s = 0; s < 2; s++) begin : g_slot
      assign slot_filling[s] = fill_busy & act_ok_q[s] & (act_q[s] == fill_win);
    end
  endgenerate

  assign cmd_go        = cmd_valid & ~fill_busy;
  assign vic_take      = cmd_go & ~hit & vic_ok;
  assign wr_win        = act_q[wr_sel];
  assign wr_fire       = wr_en & act_ok_q[wr_sel] & ~slot_filling[wr_sel];
  assign spill_restart = wr_fire & spill_busy & (wr_win == spill_win);
  assign fill_beat     = fill_busy & mem_req & mem_ready;
  assign fill_last     = fill_beat & (fill_cnt == XW'(WORDS - 1));

  assign cmd_ready = (cmd_go & (hit | (vic_ok & (cmd_kind_e'(cmd_alloc) == K_ALLOC))))
                   | fill_last;
  assign rd_stall  = (rd0_en & slot_filling[rd0_sel]) |
                     (rd1_en & slot_filling[rd1_sel]) |
                     (wr_en  & slot_filling[wr_sel]);
  assign rd0_data  = data_q[act_q[rd0_sel]][rd0_idx];
  assign rd1_data  = data_q[act_q[rd1_sel]][rd1_idx];

  // Data-cache port: fill has priority, both yield to ext_busy.
  assign mem_req   = (fill_busy & ~ext_busy) | spill_req;
  assign mem_we    = ~fill_busy;
  assign mem_addr  = fill_busy ? word_addr(tag_q[fill_win], 32'(fill_cnt))
                               : word_addr(tag_q[spill_win], 32'(spill_idx));
  assign mem_wdata = data_q[spill_win][spill_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      dirty_q   <= '0;
      act_ok_q  <= '0;
      fill_busy <= 1'b0;
      fill_win  <= '0;
      fill_cnt  <= '0;
      act_q[0]  <= '0;
      act_q[1]  <= '0;
      for (int w = 0; w < NWIN; w++) begin
        tag_q[w] <= '0;
        for (int k = 0; k < WORDS; k++) data_q[w][k] <= '0;
      end
    end else begin
      if (spill_done) dirty_q[spill_win] <= 1'b0;

      if (cmd_go && hit) begin
        act_q[cmd_slot]    <= hit_idx;
        act_ok_q[cmd_slot] <= 1'b1;
      end else if (vic_take) begin
        tag_q[vic_idx]     <= cmd_addr;
        dirty_q[vic_idx]   <= 1'b0;
        act_q[cmd_slot]    <= vic_idx;
        act_ok_q[cmd_slot] <= 1'b1;
        if (cmd_kind_e'(cmd_alloc) == K_ALLOC) begin
          valid_q[vic_idx] <= 1'b1;
          for (int k = 0; k < WORDS; k++) data_q[vic_idx][k] <= '0;
        end else begin
          valid_q[vic_idx] <= 1'b0;
          fill_busy        <= 1'b1;
          fill_win         <= vic_idx;
          fill_cnt         <= '0;
        end
      end

      if (fill_beat) begin
        data_q[fill_win][fill_cnt] <= mem_rdata;
        fill_cnt <= fill_cnt + XW'(1);
        if (fill_last) begin
          valid_q[fill_win] <= 1'b1;
          fill_busy         <= 1'b0;
        end
      end

      if (wr_fire) begin
        data_q[wr_win][wr_idx] <= wr_data;
        dirty_q[wr_win]        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/regwin_cache_chk.sv
module regwin_cache_chk #(
  parameter int NWIN  = 4,
  parameter int WORDS = 8,
  localparam int IW   = $clog2(NWIN),
  localparam int XW   = $clog2(WORDS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ready,
  input logic            cmd_ready,
  input logic            fill_last,
  input logic            wr_fire,
  input logic [IW-1:0]   wr_win,
  input logic [NWIN-1:0] dirty_q,
  input logic            vic_take,
  input logic [IW-1:0]   vic_idx,
  input logic [IW-1:0]   act0,
  input logic [IW-1:0]   act1,
  input logic [1:0]      act_ok
);
  // Read beats seen since the last completed command.
  logic [XW:0] rbeats;
  always_ff @(posedge clk) begin
    if (!rst_n)                            rbeats <= '0;
    else if (cmd_ready)                    rbeats <= '0;
    else if (mem_req && !mem_we && mem_ready) rbeats <= rbeats + (XW+1)'(1);
  end

  p_yield_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_busy |-> !mem_req);

  p_fill_eight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> (rbeats == (XW+1)'(WORDS - 1)));

  p_dirty_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> dirty_q[$past(wr_win)]);

  p_keep_slot0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_take && act_ok[0]) |-> (vic_idx != act0));

  p_keep_slot1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_take && act_ok[1]) |-> (vic_idx != act1));

  p_clean_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vic_take |-> !dirty_q[vic_idx]);
endmodule

bind regwin_cache regwin_cache_chk #(.NWIN(NWIN), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_busy(ext_busy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ready(mem_ready), .cmd_ready(cmd_ready),
  .fill_last(fill_last), .wr_fire(wr_fire), .wr_win(wr_win),
  .dirty_q(dirty_q), .vic_take(vic_take), .vic_idx(vic_idx),
  .act0(act_q[0]), .act1(act_q[1]), .act_ok(act_ok_q)
);

// File: tb/test_regwin_cache.sv
module test_regwin_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_alloc = 0, cmd_slot = 0;
  logic [31:0] cmd_addr = '0;
  logic        cmd_ready;
  logic        rd0_en = 0, rd0_sel = 0, rd1_en = 0, rd1_sel = 0;
  logic [2:0]  rd0_idx = '0, rd1_idx = '0;
  logic [31:0] rd0_data, rd1_data;
  logic        wr_en = 0, wr_sel = 0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rd_stall, ext_busy = 0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;

  int checks = 0, errors = 0;
  int rd_beats = 0, wr_beats = 0;
  logic [31:0] bmem [64];

  always #4 clk = ~clk;

  regwin_cache i_regwin_cache (.*);

  // Memory model: read data in the accepting cycle, writes at the edge.
  assign mem_rdata = bmem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) bmem[i] <= 32'hA000_0000 | 32'(i);
    end else if (mem_req && mem_ready) begin
      if (mem_we) begin
        bmem[mem_addr[7:2]] <= mem_wdata;
        wr_beats <= wr_beats + 1;
      end else rd_beats <= rd_beats + 1;
    end
  end

  // slot, index, value
  localparam logic [35:0] TBL [6] = '{
    {1'b0, 3'd0, 32'h1111_1111}, {1'b0, 3'd7, 32'h2222_2222},
    {1'b1, 3'd3, 32'h3333_3333}, {1'b1, 3'd7, 32'h4444_4444},
    {1'b0, 3'd4, 32'h5555_5555}, {1'b1, 3'd0, 32'h6666_6666}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_cmd(input logic kind, input logic slot, input logic [31:0] addr,
                         output int cyc);
    @(negedge clk);
    cmd_valid = 1; cmd_alloc = kind; cmd_slot = slot; cmd_addr = addr; cyc = 0;
    forever begin
      #1; cyc++;
      if (cmd_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wr(input logic sel, input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = val;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [2:0] idx,
                    input logic [31:0] exp);
    @(negedge clk);
    rd0_sel = sel; rd0_idx = idx; rd1_sel = sel; rd1_idx = idx;
    #1;
    chk({req, " port0"}, rd0_data, exp);
    chk({req, " port1"}, rd1_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cyc, snap;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    #1;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 0);
    chk("R1 rd_stall", 32'(rd_stall), 0);
    chk("R1 read zero", rd0_data, 0);

    // R2 load miss: 1 lookup cycle + 8 beats
    snap = rd_beats;
    run_cmd(1'b0, 1'b0, 32'h40, cyc);
    chk("R2 load cycles", 32'(cyc), 9);
    chk("R2 read beats", 32'(rd_beats - snap), 8);
    for (int k = 0; k < 8; k++) rd("R2 filled word", 1'b0, 3'(k), 32'hA000_0010 + 32'(k));

    // R4 stall while slot 1 fills; write during stall dropped
    @(negedge clk);
    cmd_valid = 1; cmd_alloc = 0; cmd_slot = 1; cmd_addr = 32'h60;
    #1 chk("R4 no ready on miss", 32'(cmd_ready), 0);
    @(negedge clk);
    rd1_en = 1; rd1_sel = 1; wr_en = 1; wr_sel = 1; wr_idx = 3'd0; wr_data = 32'hDEAD_BEEF;
    #1 chk("R4 stall on filling slot", 32'(rd_stall), 1);
    @(negedge clk);
    wr_en = 0;
    forever begin #1; if (cmd_ready) break; @(negedge clk); end
    @(negedge clk); cmd_valid = 0; rd1_en = 0;
    #1 chk("R4 stall released", 32'(rd_stall), 0);
    rd("R4 dropped write", 1'b1, 3'd0, 32'hA000_0018);
    rd("R2 slot1 word7", 1'b1, 3'd7, 32'hA000_001F);

    // R3 table of writes then read back on both ports; spills held off
    ext_busy = 1;
    for (int i = 0; i < 6; i++) wr(TBL[i][35], TBL[i][34:32], TBL[i][31:0]);
    for (int i = 0; i < 6; i++) rd("R3 readback", TBL[i][35], TBL[i][34:32], TBL[i][31:0]);

    // R8 no request while port is owned elsewhere
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 chk("R8 yield", 32'(mem_req), 0);
    end

    // R5 allocate misses: immediate, no reads, zeroed
    snap = rd_beats;
    run_cmd(1'b1, 1'b1, 32'h80, cyc);
    chk("R5 alloc cycles", 32'(cyc), 1);
    rd("R5 alloc zero", 1'b1, 3'd5, 32'h0);
    run_cmd(1'b1, 1'b0, 32'hA0, cyc);
    chk("R5 alloc cycles 2", 32'(cyc), 1);
    chk("R5 no read beats", 32'(rd_beats - snap), 0);

    // R9 all unbound windows dirty: command waits for a copy-back
    @(negedge clk);
    cmd_valid = 1; cmd_alloc = 1; cmd_slot = 1; cmd_addr = 32'hC0;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R9 stalled ready", 32'(cmd_ready), 0);
      chk("R8 yield while stalled", 32'(mem_req), 0);
      @(negedge clk);
    end
    ext_busy = 0; cyc = 0;
    forever begin #1; cyc++; if (cmd_ready) break; @(negedge clk); end
    @(negedge clk); cmd_valid = 0;
    chk("R9 wait one copy-back", 32'(cyc), 9);
    rd("R9 slot0 still bound", 1'b0, 3'd1, 32'h0);
    repeat (14) @(negedge clk);
    chk("R7 spill w0 word0", bmem[16], 32'h1111_1111);
    chk("R7 spill w0 word4", bmem[20], 32'h5555_5555);
    chk("R7 spill w0 word7", bmem[23], 32'h2222_2222);
    chk("R7 spill w0 word1", bmem[17], 32'hA000_0011);
    chk("R7 spill w1 word0", bmem[24], 32'h6666_6666);
    chk("R7 spill w1 word3", bmem[27], 32'h3333_3333);
    chk("R7 spill w1 word7", bmem[31], 32'h4444_4444);

    // R6 hit on resident window
    snap = rd_beats;
    run_cmd(1'b0, 1'b1, 32'h60, cyc);
    chk("R6 hit cycles", 32'(cyc), 1);
    chk("R6 no read beats", 32'(rd_beats - snap), 0);
    rd("R6 contents kept", 1'b1, 3'd3, 32'h3333_3333);

    // R10 write during copy-back restarts it
    snap = wr_beats;
    wr(1'b1, 3'd2, 32'h7777_7777);
    repeat (3) @(negedge clk);
    wr(1'b1, 3'd2, 32'h8888_8888);
    repeat (20) @(negedge clk);
    chk("R10 newest data in memory", bmem[26], 32'h8888_8888);
    chk("R10 restart beats", 32'((wr_beats - snap) > 8), 1);
    chk("R10 port idle after", 32'(mem_req), 0);

    finish_run();
  end
endmodule